// File: doc/BRIEF.md
# Head-of-Queue Age Discarder for a Switch Port

This block ages the packets waiting in one port's three input queues (posted, non-posted, completion). It keeps a coarse time counter that advances on a timebase pulse. For each class it holds a small FIFO of arrival stamps, so a stamp is written whenever the outside buffer enqueues a packet. The block examines the stamp of a queue's head entry only while that entry sits at the head. If the entry's age exceeds a programmable limit, the block pulses a discard for that class. The buffer then drops its head packet.

Every discard bumps a saturating drop counter for its class. A single read strobe clears all three counters, and software samples the values on the cycle of the strobe. A posted discard may also raise a request for a non-fatal error message. The request is held back when reporting is disabled, when the silent bit is set, or when the posted counter has already reached its ceiling. Non-posted and completion discards never raise a message, because their requesters notice the loss through their own completion timeouts.

Top module: `hoq_timeout_discard`

## Requirements
- R1: After reset, all discard strobes and the message request are low, and all three drop counters read 0.
- R2: A head entry whose age (current time minus stamp, modulo 2^TS_W) exceeds LIMIT ticks is discarded. An age equal to LIMIT is not discarded. The discard is a one-cycle pulse on `discard_o`, with bit 0 for posted, bit 1 for non-posted and bit 2 for completion. It rises in the cycle after the expiry condition holds.
- R3: A discard increments only its own class counter, and the new value is visible in the same cycle as the discard pulse.
- R4: Each counter saturates at 2^CNT_W-1 and holds there on further discards.
- R5: A high `cnt_rd_i` clears all three counters at the next edge. If a discard coincides with the read, the counter of that class becomes 1.
- R6: `err_msg_req_o` pulses together with a posted discard only when `nf_report_en_i` is 1, `silent_posted_i` is 0 and the posted count before the discard is below its ceiling. A read in the same cycle counts as bringing it to 0. The request never pulses for other classes.
- R7: With `silent_posted_i` set, a posted discard raises no message but still increments the posted counter.
- R8: An entry is not aged out while `head_valid_i` of its class is low. Once the signal rises, an entry that is already over age is discarded in the following cycle.
- R9: Entries behind the head keep their own stamps. A normal `deq_i` removes the head stamp without a discard.
- R10: Age is computed correctly when the time counter wraps between the stamp and the check.
- R11: A class never discards on two consecutive cycles. While a class's discard pulse is high, that class is not examined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase pulse advancing the time counter |
| nf_report_en_i | input | 1 | Non-fatal error reporting enable |
| silent_posted_i | input | 1 | Suppress messages for posted discards |
| enq_i | input | 3 | Per-class enqueue (stamp written) |
| deq_i | input | 3 | Per-class normal dequeue of the head |
| head_valid_i | input | 3 | Per-class head entry present in the buffer |
| cnt_rd_i | input | 1 | Counter read strobe, clears all counters |
| discard_o | output | 3 | Per-class discard pulse |
| posted_cnt_o | output | CNT_W | Posted drop count |
| nonposted_cnt_o | output | CNT_W | Non-posted drop count |
| cpl_cnt_o | output | CNT_W | Completion drop count |
| err_msg_req_o | output | 1 | Non-fatal message request |

## Verification
Two functions can fall in the same cycle: a counter read clearing the counters, and a discard incrementing one of them. The bench makes them coincide by raising the read strobe in exactly the cycle after the tick that pushes a completion entry over age. It then expects that class's counter to show 1 while the others show 0. The same overlap matters for message gating, since a saturated posted count blocks the message. That path is judged in a burst of back-to-back posted expiries crossing the ceiling: the first discard still requests a message and the later ones do not.

// File: rtl/hoq_pkg.sv
package hoq_pkg;
  localparam int NCLS    = 3;
  localparam int IDX_P   = 0;  // posted
  localparam int IDX_NP  = 1;  // non-posted
  localparam int IDX_CPL = 2;  // completion
endpackage

// File: rtl/hoq_stamp_fifo.sv
module hoq_stamp_fifo #(
  parameter int TS_W  = 8,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [TS_W-1:0] push_stamp,
  input  logic            pop,
  output logic [TS_W-1:0] head_stamp,
  output logic            empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TS_W-1:0] mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW:0]     fill;
  logic            full, do_push, do_pop;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_stamp;
  end

  assign head_stamp = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R9: stamps must never be lost to an overfull queue
  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/hoq_drop_counter.sv
module hoq_drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (clr)                  count <= inc ? CNT_W'(1) : '0;
    else if (inc && count != CMAX) count <= count + 1'b1;
  end

  a_r4_hold_at_ceiling: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && !clr) |=> count == CMAX);
  a_r5_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc) |=> count == '0);
  a_r5_clear_with_inc: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> count == CNT_W'(1));
endmodule

// File: rtl/hoq_timeout_discard.sv
module hoq_timeout_discard
  import hoq_pkg::*;
#(
  parameter int TS_W  = 8,
  parameter int LIMIT = 50,
  parameter int DEPTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             nf_report_en_i,
  input  logic             silent_posted_i,
  input  logic [NCLS-1:0]  enq_i,
  input  logic [NCLS-1:0]  deq_i,
  input  logic [NCLS-1:0]  head_valid_i,
  input  logic             cnt_rd_i,
  output logic [NCLS-1:0]  discard_o,
  output logic [CNT_W-1:0] posted_cnt_o,
  output logic [CNT_W-1:0] nonposted_cnt_o,
  output logic [CNT_W-1:0] cpl_cnt_o,
  output logic             err_msg_req_o
);
  localparam logic [TS_W-1:0]  LIM_T = TS_W'(LIMIT);
  localparam logic [CNT_W-1:0] CMAX  = '1;

  logic [TS_W-1:0]  now_q;
  logic [TS_W-1:0]  head_stamp [NCLS];
  logic [CNT_W-1:0] counts     [NCLS];
  logic [NCLS-1:0]  fifo_empty, expired;
  logic             posted_full, msg_d;

  // coarse free-running time base
  always_ff @(posedge clk) begin
    if (rst)         now_q <= '0;
    else if (tick_i) now_q <= now_q + 1'b1;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [TS_W-1:0] age;

    hoq_stamp_fifo #(.TS_W(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk        (clk),
      .rst        (rst),
      .push       (enq_i[c]),
      .push_stamp (now_q),
      .pop        (deq_i[c] | expired[c]),
      .head_stamp (head_stamp[c]),
      .empty      (fifo_empty[c])
    );

    assign age = now_q - head_stamp[c];
    assign expired[c] = head_valid_i[c] && !fifo_empty[c] && !discard_o[c]
                        && !deq_i[c] && (age > LIM_T);

    hoq_drop_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (expired[c]),
      .clr   (cnt_rd_i),
      .count (counts[c])
    );

    a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
      discard_o[c] |=> !discard_o[c]);
    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
      (expired[c] && !cnt_rd_i && counts[c] != CMAX)
        |=> counts[c] == $past(counts[c]) + 1'b1);
  end

  assign posted_full = (counts[IDX_P] == CMAX) && !cnt_rd_i;
  assign msg_d = expired[IDX_P] && nf_report_en_i && !silent_posted_i && !posted_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      discard_o     <= '0;
      err_msg_req_o <= 1'b0;
    end else begin
      discard_o     <= expired;
      err_msg_req_o <= msg_d;
    end
  end

  assign posted_cnt_o    = counts[IDX_P];
  assign nonposted_cnt_o = counts[IDX_NP];
  assign cpl_cnt_o       = counts[IDX_CPL];

  a_r6_msg_with_posted: assert property (@(posedge clk) disable iff (rst)
    err_msg_req_o |-> discard_o[IDX_P]);
  a_r7_msg_gated: assert property (@(posedge clk) disable iff (rst)
    err_msg_req_o |-> $past(nf_report_en_i && !silent_posted_i));
endmodule

// File: tb/hoq_timeout_discard_test.sv
module hoq_timeout_discard_test;
  localparam int TS_W = 4, LIMIT = 5, DEPTH = 4, CNT_W = 3;

  logic clk = 1'b0, rst = 1'b1, tick_i = 1'b0;
  logic nf_report_en_i = 1'b1, silent_posted_i = 1'b0, cnt_rd_i = 1'b0;
  logic [2:0] enq_i = '0, deq_i = '0, head_valid_i, discard_o;
  logic [CNT_W-1:0] posted_cnt_o, nonposted_cnt_o, cpl_cnt_o;
  logic err_msg_req_o;

  int errors = 0, checks = 0, bench_now = 0;
  int occ [3] = '{0, 0, 0};
  bit hold [3] = '{0, 0, 0};
  bit prev_disc [3] = '{0, 0, 0};
  bit    exp_msg [3][$];
  string exp_tag [3][$];

  always #5 clk = ~clk;

  hoq_timeout_discard #(.TS_W(TS_W), .LIMIT(LIMIT), .DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .nf_report_en_i(nf_report_en_i),
    .silent_posted_i(silent_posted_i), .enq_i(enq_i), .deq_i(deq_i),
    .head_valid_i(head_valid_i), .cnt_rd_i(cnt_rd_i), .discard_o(discard_o),
    .posted_cnt_o(posted_cnt_o), .nonposted_cnt_o(nonposted_cnt_o),
    .cpl_cnt_o(cpl_cnt_o), .err_msg_req_o(err_msg_req_o));

  always_comb
    for (int c = 0; c < 3; c++) head_valid_i[c] = (occ[c] > 0) && !hold[c];

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int cnt_of(int c);
    return (c == 0) ? int'(posted_cnt_o) : (c == 1) ? int'(nonposted_cnt_o) : int'(cpl_cnt_o);
  endfunction

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (err_msg_req_o && !discard_o[0])
        chk(1'b0, "R6 message without posted discard", 1, 0);
      for (int c = 0; c < 3; c++) begin
        if (discard_o[c]) begin
          if (prev_disc[c]) chk(1'b0, "R11 back-to-back discard", c, -1);
          if (exp_msg[c].size() == 0) begin
            chk(1'b0, "R2 unexpected discard class", c, -1);
          end else begin
            bit m;
            string t;
            m = exp_msg[c].pop_front();
            t = exp_tag[c].pop_front();
            chk(err_msg_req_o == m, t, int'(err_msg_req_o), int'(m));
          end
          occ[c]--;
        end
        prev_disc[c] = discard_o[c];
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic settle(int n); repeat (n) step(); endtask

  task automatic enq(int c);
    enq_i[c] = 1'b1; occ[c]++; step(); enq_i[c] = 1'b0;
  endtask

  task automatic deq(int c);
    deq_i[c] = 1'b1; step(); deq_i[c] = 1'b0; occ[c]--;
  endtask

  task automatic tick_n(int n);
    repeat (n) begin tick_i = 1'b1; step(); tick_i = 1'b0; bench_now++; end
  endtask

  task automatic expect_disc(int c, bit m, string tag);
    exp_msg[c].push_back(m); exp_tag[c].push_back(tag);
  endtask

  task automatic drained(string tag);
    int n = exp_msg[0].size() + exp_msg[1].size() + exp_msg[2].size();
    chk(n == 0, tag, n, 0);
  endtask

  task automatic cnts(int p, int np, int cp, string tag);
    chk(cnt_of(0) == p,  {tag, " posted"},     cnt_of(0), p);
    chk(cnt_of(1) == np, {tag, " non-posted"}, cnt_of(1), np);
    chk(cnt_of(2) == cp, {tag, " completion"}, cnt_of(2), cp);
  endtask

  // one entry aged exactly to the limit, then past it
  task automatic age_out(int c, bit m, string tag);
    enq(c);
    tick_n(LIMIT);
    settle(3);
    drained({tag, " R2 age equal to limit kept"});
    expect_disc(c, m, tag);
    tick_n(1);
    settle(3);
    drained({tag, " discard seen"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(3);
    rst = 1'b0;
    step();
    // R1 reset state
    chk(discard_o == 3'b000, "R1 discard after reset", int'(discard_o), 0);
    chk(err_msg_req_o == 1'b0, "R1 message after reset", int'(err_msg_req_o), 0);
    cnts(0, 0, 0, "R1");

    age_out(0, 1'b1, "R2 R6 posted with message");
    cnts(1, 0, 0, "R3 posted");
    age_out(1, 1'b0, "R6 non-posted no message");
    cnts(1, 1, 0, "R3 non-posted");
    age_out(2, 1'b0, "R6 completion no message");
    cnts(1, 1, 1, "R3 completion");

    silent_posted_i = 1'b1;
    age_out(0, 1'b0, "R7 silent posted");
    cnts(2, 1, 1, "R7 count still updated");
    silent_posted_i = 1'b0;

    nf_report_en_i = 1'b0;
    age_out(0, 1'b0, "R6 reporting disabled");
    cnts(3, 1, 1, "R6 disabled count");
    nf_report_en_i = 1'b1;

    // R8 head not presented
    hold[0] = 1'b1;
    enq(0);
    tick_n(LIMIT + 3);
    settle(3);
    cnts(3, 1, 1, "R8 held head not aged out");
    expect_disc(0, 1'b1, "R8 released head");
    hold[0] = 1'b0;
    settle(3);
    drained("R8 discard after release");
    cnts(4, 1, 1, "R8");

    // R9 entry behind head keeps its own stamp
    enq(0);
    tick_n(3);
    enq(0);
    expect_disc(0, 1'b1, "R9 first entry");
    tick_n(3);
    settle(3);
    drained("R9 first discard");
    tick_n(2);
    settle(3);
    cnts(5, 1, 1, "R9 second entry still young");
    expect_disc(0, 1'b1, "R9 second entry");
    tick_n(1);
    settle(3);
    drained("R9 second discard");
    cnts(6, 1, 1, "R9");

    // R9 normal dequeue removes the stamp
    enq(1);
    tick_n(2);
    deq(1);
    tick_n(10);
    settle(3);
    cnts(6, 1, 1, "R9 dequeued entry not dropped");
    age_out(1, 1'b0, "R9 fresh stamp after dequeue");
    cnts(6, 2, 1, "R9 after dequeue");

    // R4 and R11: burst crossing the ceiling
    enq(0); enq(0); enq(0);
    expect_disc(0, 1'b1, "R6 last discard below ceiling");
    expect_disc(0, 1'b0, "R4 R6 saturated no message");
    expect_disc(0, 1'b0, "R4 R6 saturated no message");
    tick_n(LIMIT + 1);
    settle(10);
    drained("R11 burst drained");
    cnts(7, 2, 1, "R4 saturated");

    // R5 read clears
    cnt_rd_i = 1'b1; step(); cnt_rd_i = 1'b0;
    cnts(0, 0, 0, "R5 cleared by read");

    // R5 read coinciding with increment
    enq(2);
    expect_disc(2, 1'b0, "R5 coincident completion");
    tick_n(LIMIT);
    tick_i = 1'b1; step(); tick_i = 1'b0; bench_now++;
    cnt_rd_i = 1'b1; step(); cnt_rd_i = 1'b0;
    cnts(0, 0, 1, "R5 read and increment");
    settle(2);
    drained("R5 discard seen");

    // R10 stamp taken just before wrap
    tick_n((13 - (bench_now % 16) + 16) % 16);
    age_out(0, 1'b1, "R10 wrap");
    cnts(1, 0, 1, "R10 count");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule